// File: doc/BRIEF.md
# Dual-Mode Serial Character Receiver

This block turns a serial data line into parallel characters. It has two modes, and a configuration input picks one. In oversampled mode a baud-rate enable pulses sixteen times per bit. A falling edge on the idle line starts a frame, and the receiver confirms it halfway through the start bit before it takes each following bit at its middle sample. In clocked mode a baud clock arrives with the data. The receiver takes one sample per bit on each rising edge of that clock, and a low level seen while idle begins a frame.

Both modes share one framing engine, so the data length, parity enable, parity sense and the single stop bit behave the same way in each. Each finished character lands in a holding register and sets a ready flag. Software or a consumer clears that flag with a read strobe. A character that completes while the previous one is still unread sets an overrun flag. Parity and framing problems set their own flags. These three error flags stay set until a status-reset command. An interrupt request follows the ready flag when its enable is on.

Top module: `duo_rx`

## Requirements
- R1: In oversampled mode a bit lasts OVS (default 16) `baud_tick` samples. A low line at a tick while idle is sample 0. The frame goes on only if the line is still low at sample OVS/2 (8). Otherwise the receiver returns to idle with no character, and it accepts the next proper frame normally.
- R2: In clocked mode the line is sampled once on each rising edge of `sclk`, one sample per bit. A low sample while idle is taken as the start bit.
- R3: Frame order in both modes is: a low start bit, DATA_W data bits with the least significant bit first, one parity bit only when `par_en` is 1, and one stop bit.
- R4: When a frame's stop bit is sampled, the data bits go to `rx_data` and `rx_ready` rises on the next clock edge. `rx_data` changes only when a character completes.
- R5: A one-cycle `rd_strobe` clears `rx_ready`, unless a character completes in that same cycle.
- R6: If a character completes while `rx_ready` is 1, `overrun` is set and `rx_data` takes the new character.
- R7: With `par_odd` = 0 the parity bit must equal the XOR of the data bits (even parity). With `par_odd` = 1 it must equal the inverse of that XOR. A mismatch sets the sticky `parity_err`, and the character is still stored.
- R8: A low stop-bit sample sets the sticky `frame_err`, and the character is still stored.
- R9: `clr_status` clears `overrun`, `parity_err` and `frame_err` and leaves `rx_ready` and `rx_data` as they were.
- R10: `irq` is 1 exactly when `rx_ready` and `irq_en` are both 1. After reset all flags and `irq` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rxd | input | 1 | Serial data line, idle high |
| baud_tick | input | 1 | Oversampling enable, OVS pulses per bit (oversampled mode) |
| sclk | input | 1 | Baud clock sampled on its rising edge (clocked mode) |
| mode_sync | input | 1 | 1 selects clocked mode, 0 oversampled mode |
| par_en | input | 1 | Parity bit present and checked |
| par_odd | input | 1 | 1 selects odd parity, 0 even |
| irq_en | input | 1 | Interrupt enable for the ready flag |
| rd_strobe | input | 1 | Holding-register read, clears ready |
| clr_status | input | 1 | Clears overrun, parity and framing flags |
| rx_data | output | DATA_W | Holding register |
| rx_ready | output | 1 | Character available |
| overrun | output | 1 | Sticky overrun flag |
| parity_err | output | 1 | Sticky parity error flag |
| frame_err | output | 1 | Sticky framing error flag |
| irq | output | 1 | Interrupt request |

## Verification
The hardest case to reach is the rejected start bit. The line must drop at a sample tick and come back high before the eighth sample that follows. Then the receiver has to be shown to be back in idle and not stalled partway through a frame. The stimulus holds the line low for only three ticks and waits two bit times. It checks that no character appeared and then sends a full frame, which must arrive intact. Overrun is reached by turning off the bench's automatic reads, so that two frames complete back to back.

// File: rtl/duo_rx_pkg.sv
package duo_rx_pkg;
   typedef enum logic [2:0] {
      ST_IDLE  = 3'd0,
      ST_START = 3'd1,
      ST_DATA  = 3'd2,
      ST_PAR   = 3'd3,
      ST_STOP  = 3'd4
   } rx_state_e;
endpackage

// File: rtl/duo_rx_sync.sv
module duo_rx_sync #(
   parameter int STAGES = 2,
   parameter bit IDLE_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic dout
);
   generate
      if (STAGES == 0) begin : g_pass
         assign dout = din;
      end else begin : g_chain
         logic [STAGES-1:0] chain_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q <= {STAGES{IDLE_VAL}};
            else if (STAGES == 1) chain_q <= din;
            else chain_q <= {chain_q[STAGES-2:0], din};
         end
         assign dout = chain_q[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/duo_rx_frame.sv
module duo_rx_frame
   import duo_rx_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int OVS    = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              samp_en,
   input  logic              line,
   input  logic              mode_sync,
   input  logic              par_en,
   input  logic              par_odd,
   output logic              done,
   output logic [DATA_W-1:0] chr,
   output logic              perr,
   output logic              ferr
);
   localparam int CNT_W = $clog2(OVS);
   localparam int IDX_W = $clog2(DATA_W + 1);
   localparam logic [CNT_W-1:0] MID_M1 = CNT_W'(OVS / 2 - 1);
   localparam logic [CNT_W-1:0] LAST   = CNT_W'(OVS - 1);
   localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(DATA_W - 1);

   rx_state_e         st;
   logic [CNT_W-1:0]  cnt;
   logic [IDX_W-1:0]  idx;
   logic [DATA_W-1:0] sh;
   logic              pbit;
   logic              at_bit;

   assign at_bit = samp_en && (mode_sync || cnt == LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st   <= ST_IDLE;
         cnt  <= '0;
         idx  <= '0;
         sh   <= '0;
         pbit <= 1'b0;
         done <= 1'b0;
         chr  <= '0;
         perr <= 1'b0;
         ferr <= 1'b0;
      end else begin
         done <= 1'b0;
         if (samp_en && !at_bit) cnt <= cnt + 1'b1;
         unique case (st)
            ST_IDLE: begin
               if (samp_en && !line) begin
                  cnt <= '0;
                  idx <= '0;
                  st  <= mode_sync ? ST_DATA : ST_START;
               end
            end
            ST_START: begin
               if (samp_en && cnt == MID_M1) begin
                  cnt <= '0;
                  st  <= line ? ST_IDLE : ST_DATA;
               end
            end
            ST_DATA: begin
               if (at_bit) begin
                  cnt <= '0;
                  sh  <= {line, sh[DATA_W-1:1]};
                  if (idx == IDX_LAST) begin
                     idx <= '0;
                     st  <= par_en ? ST_PAR : ST_STOP;
                  end else begin
                     idx <= idx + 1'b1;
                  end
               end
            end
            ST_PAR: begin
               if (at_bit) begin
                  cnt  <= '0;
                  pbit <= line;
                  st   <= ST_STOP;
               end
            end
            ST_STOP: begin
               if (at_bit) begin
                  cnt  <= '0;
                  done <= 1'b1;
                  chr  <= sh;
                  perr <= par_en && (pbit != ((^sh) ^ par_odd));
                  ferr <= !line;
                  st   <= ST_IDLE;
               end
            end
            default: st <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/duo_rx_status.sv
module duo_rx_status #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              done,
   input  logic [DATA_W-1:0] chr,
   input  logic              perr_in,
   input  logic              ferr_in,
   input  logic              rd_strobe,
   input  logic              clr_status,
   input  logic              irq_en,
   output logic [DATA_W-1:0] rx_data,
   output logic              rx_ready,
   output logic              overrun,
   output logic              parity_err,
   output logic              frame_err,
   output logic              irq
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rx_data    <= '0;
         rx_ready   <= 1'b0;
         overrun    <= 1'b0;
         parity_err <= 1'b0;
         frame_err  <= 1'b0;
      end else begin
         if (done) rx_data <= chr;

         if (done) rx_ready <= 1'b1;
         else if (rd_strobe) rx_ready <= 1'b0;

         if (done && rx_ready) overrun <= 1'b1;
         else if (clr_status) overrun <= 1'b0;

         if (done && perr_in) parity_err <= 1'b1;
         else if (clr_status) parity_err <= 1'b0;

         if (done && ferr_in) frame_err <= 1'b1;
         else if (clr_status) frame_err <= 1'b0;
      end
   end

   assign irq = rx_ready && irq_en;
endmodule

// File: rtl/duo_rx.sv
module duo_rx #(
   parameter int DATA_W      = 8,
   parameter int OVS         = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rxd,
   input  logic              baud_tick,
   input  logic              sclk,
   input  logic              mode_sync,
   input  logic              par_en,
   input  logic              par_odd,
   input  logic              irq_en,
   input  logic              rd_strobe,
   input  logic              clr_status,
   output logic [DATA_W-1:0] rx_data,
   output logic              rx_ready,
   output logic              overrun,
   output logic              parity_err,
   output logic              frame_err,
   output logic              irq
);
   generate
      if (OVS < 4 || (OVS % 2) != 0) begin : g_bad_ovs
         $error("duo_rx: OVS must be even and at least 4");
      end
      if (DATA_W < 1) begin : g_bad_width
         $error("duo_rx: DATA_W must be at least 1");
      end
   endgenerate

   logic              line_s;
   logic              sclk_s;
   logic              sclk_q;
   logic              samp_en;
   logic              char_done;
   logic [DATA_W-1:0] char_val;
   logic              char_perr;
   logic              char_ferr;

   duo_rx_sync #(.STAGES(SYNC_STAGES), .IDLE_VAL(1'b1)) u_sync_line (
      .clk(clk), .rst_n(rst_n), .din(rxd), .dout(line_s));

   duo_rx_sync #(.STAGES(SYNC_STAGES), .IDLE_VAL(1'b0)) u_sync_clk (
      .clk(clk), .rst_n(rst_n), .din(sclk), .dout(sclk_s));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sclk_q <= 1'b0;
      else sclk_q <= sclk_s;
   end

   assign samp_en = mode_sync ? (sclk_s && !sclk_q) : baud_tick;

   duo_rx_frame #(.DATA_W(DATA_W), .OVS(OVS)) u_frame (
      .clk(clk), .rst_n(rst_n), .samp_en(samp_en), .line(line_s),
      .mode_sync(mode_sync), .par_en(par_en), .par_odd(par_odd),
      .done(char_done), .chr(char_val), .perr(char_perr), .ferr(char_ferr));

   duo_rx_status #(.DATA_W(DATA_W)) u_status (
      .clk(clk), .rst_n(rst_n), .done(char_done), .chr(char_val),
      .perr_in(char_perr), .ferr_in(char_ferr), .rd_strobe(rd_strobe),
      .clr_status(clr_status), .irq_en(irq_en), .rx_data(rx_data),
      .rx_ready(rx_ready), .overrun(overrun), .parity_err(parity_err),
      .frame_err(frame_err), .irq(irq));
endmodule

// File: rtl/duo_rx_chk.sv
module duo_rx_chk #(
   parameter int DATA_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              done,
   input logic              rd_strobe,
   input logic              clr_status,
   input logic [DATA_W-1:0] rx_data,
   input logic              rx_ready,
   input logic              overrun,
   input logic              parity_err,
   input logic              frame_err
);
   a_r4_ready_after_done: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> rx_ready);

   a_r4_data_held: assert property (@(posedge clk) disable iff (!rst_n)
      !done |=> $stable(rx_data));

   a_r5_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
      rd_strobe && !done |=> !rx_ready);

   a_r6_overrun_on_full: assert property (@(posedge clk) disable iff (!rst_n)
      done && rx_ready |=> overrun);

   a_r6_overrun_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      overrun && !clr_status |=> overrun);

   a_r7_parity_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      parity_err && !clr_status |=> parity_err);

   a_r8_frame_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      frame_err && !clr_status |=> frame_err);

   a_r9_clear_flags: assert property (@(posedge clk) disable iff (!rst_n)
      clr_status && !done |=> !overrun && !parity_err && !frame_err);
endmodule

bind duo_rx duo_rx_chk #(.DATA_W(DATA_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .done(char_done), .rd_strobe(rd_strobe),
   .clr_status(clr_status), .rx_data(rx_data), .rx_ready(rx_ready),
   .overrun(overrun), .parity_err(parity_err), .frame_err(frame_err));

// File: tb/duo_rx_tb_top.sv
module duo_rx_tb_top;
   localparam int W = 8;

   typedef struct packed {
      logic [W-1:0] d;
      logic         pe;
      logic         fe;
   } exp_t;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         rxd = 1'b1;
   logic         baud_tick = 1'b0;
   logic         sclk = 1'b0;
   logic         mode_sync = 1'b0;
   logic         par_en = 1'b0;
   logic         par_odd = 1'b0;
   logic         irq_en = 1'b0;
   logic         mon_rd = 1'b0, tst_rd = 1'b0;
   logic         mon_clr = 1'b0, tst_clr = 1'b0;
   logic         rd_strobe, clr_status;
   logic [W-1:0] rx_data;
   logic         rx_ready, overrun, parity_err, frame_err, irq;

   int   n_chk = 0;
   int   n_bad = 0;
   bit   auto_read = 1'b1;
   bit   done_flag = 1'b0;
   exp_t exp_q[$];

   assign rd_strobe  = mon_rd | tst_rd;
   assign clr_status = mon_clr | tst_clr;

   always #2 clk = ~clk;

   duo_rx dut_i (
      .clk(clk), .rst_n(rst_n), .rxd(rxd), .baud_tick(baud_tick), .sclk(sclk),
      .mode_sync(mode_sync), .par_en(par_en), .par_odd(par_odd), .irq_en(irq_en),
      .rd_strobe(rd_strobe), .clr_status(clr_status), .rx_data(rx_data),
      .rx_ready(rx_ready), .overrun(overrun), .parity_err(parity_err),
      .frame_err(frame_err), .irq(irq));

   int tick_div = 0;
   always @(negedge clk) begin
      tick_div  <= (tick_div == 3) ? 0 : tick_div + 1;
      baud_tick <= (tick_div == 3);
   end

   task automatic chk(input bit ok, input string tag, input int act, input int exp_v);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s act=%0h exp=%0h", tag, act, exp_v);
      end
   endtask

   task automatic finish_run();
      if (!done_flag) begin
         done_flag = 1'b1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   endtask

   function automatic logic par_bit(input logic [W-1:0] d, input logic odd);
      return (^d) ^ odd;
   endfunction

   // Oversampled frame: each bit held for 16 ticks of 4 clocks
   task automatic send_async(input logic [W-1:0] d, input bit bad_par,
                             input bit bad_stop, input bit push);
      logic [W+2:0] bits;
      int nb;
      exp_t e;
      nb = 0;
      bits[nb++] = 1'b0;
      for (int i = 0; i < W; i++) bits[nb++] = d[i];
      if (par_en) bits[nb++] = par_bit(d, par_odd) ^ bad_par;
      bits[nb++] = !bad_stop;
      e.d = d; e.pe = par_en && bad_par; e.fe = bad_stop;
      if (push) exp_q.push_back(e);
      for (int b = 0; b < nb; b++) begin
         @(negedge clk) rxd = bits[b];
         repeat (63) @(negedge clk);
      end
      @(negedge clk) rxd = 1'b1;
      repeat (128) @(negedge clk);
   endtask

   task automatic sclk_cycle();
      @(negedge clk) sclk = 1'b0;
      repeat (3) @(negedge clk);
      @(negedge clk) sclk = 1'b1;
      repeat (3) @(negedge clk);
   endtask

   // Clocked frame: data changes while sclk is low
   task automatic send_sync(input logic [W-1:0] d, input bit bad_par,
                            input bit bad_stop, input bit push);
      logic [W+2:0] bits;
      int nb;
      exp_t e;
      nb = 0;
      bits[nb++] = 1'b0;
      for (int i = 0; i < W; i++) bits[nb++] = d[i];
      if (par_en) bits[nb++] = par_bit(d, par_odd) ^ bad_par;
      bits[nb++] = !bad_stop;
      e.d = d; e.pe = par_en && bad_par; e.fe = bad_stop;
      if (push) exp_q.push_back(e);
      for (int b = 0; b < nb; b++) begin
         @(negedge clk) sclk = 1'b0;
         rxd = bits[b];
         repeat (3) @(negedge clk);
         @(negedge clk) sclk = 1'b1;
         repeat (3) @(negedge clk);
      end
      @(negedge clk) rxd = 1'b1;
      repeat (4) sclk_cycle();
   endtask

   task automatic drain();
      int waited;
      waited = 0;
      while (exp_q.size() != 0 && waited < 400) begin
         @(negedge clk);
         waited++;
      end
      chk(exp_q.size() == 0, "R4 character not delivered", exp_q.size(), 0);
      exp_q.delete();
      repeat (4) @(negedge clk);
   endtask

   // Monitor: pops the scoreboard on each new character and reads it out
   initial begin
      exp_t e;
      forever begin
         @(negedge clk);
         mon_rd  = 1'b0;
         mon_clr = 1'b0;
         if (rst_n && auto_read && rx_ready) begin
            if (exp_q.size() == 0) begin
               chk(1'b0, "R4 unexpected character", rx_data, 0);
            end else begin
               e = exp_q.pop_front();
               chk(rx_data == e.d, "R3 data", rx_data, e.d);
               chk(parity_err == e.pe, "R7 parity flag", parity_err, e.pe);
               chk(frame_err == e.fe, "R8 frame flag", frame_err, e.fe);
            end
            mon_rd  = 1'b1;
            mon_clr = 1'b1;
            @(negedge clk);
            mon_rd  = 1'b0;
            mon_clr = 1'b0;
            chk(rx_ready == 1'b0, "R5 read clears ready", rx_ready, 0);
         end
      end
   end

   initial begin
      #800000;
      chk(1'b0, "watchdog expired", 0, 1);
      finish_run();
   end

   initial begin
      repeat (5) @(negedge clk);
      chk(rx_ready == 0 && overrun == 0 && parity_err == 0 && frame_err == 0 && irq == 0,
          "R10 reset state", {rx_ready, overrun, parity_err, frame_err, irq}, 0);
      rst_n = 1'b1;
      repeat (5) @(negedge clk);

      // R1 R3: oversampled mode, no parity
      send_async(8'hA5, 0, 0, 1); drain();
      send_async(8'h3C, 0, 0, 1); drain();
      send_async(8'h00, 0, 0, 1); drain();
      send_async(8'hFF, 0, 0, 1); drain();

      // R7: even and odd parity, good and bad
      par_en = 1'b1; par_odd = 1'b0;
      send_async(8'h5A, 0, 0, 1); drain();
      send_async(8'h5B, 1, 0, 1); drain();
      par_odd = 1'b1;
      send_async(8'h81, 0, 0, 1); drain();
      send_async(8'h80, 1, 0, 1); drain();
      par_en = 1'b0; par_odd = 1'b0;

      // R8: low stop bit
      send_async(8'h6E, 0, 1, 1); drain();

      // R1: short low pulse rejected, then a frame is still received
      @(negedge clk) rxd = 1'b0;
      repeat (12) @(negedge clk);
      rxd = 1'b1;
      repeat (128) @(negedge clk);
      chk(rx_ready == 1'b0, "R1 glitch gave no character", rx_ready, 0);
      send_async(8'h96, 0, 0, 1); drain();

      // R2 R3: clocked mode
      mode_sync = 1'b1;
      repeat (4) sclk_cycle();
      send_sync(8'hC3, 0, 0, 1); drain();
      send_sync(8'h01, 0, 0, 1); drain();
      par_en = 1'b1;
      send_sync(8'h17, 0, 0, 1); drain();
      send_sync(8'h17, 1, 0, 1); drain();
      send_sync(8'hE4, 0, 1, 1); drain();
      par_en = 1'b0;
      mode_sync = 1'b0;
      repeat (20) @(negedge clk);

      // R6 R9 R10: overrun with automatic reads turned off
      auto_read = 1'b0;
      irq_en = 1'b0;
      send_async(8'h11, 0, 0, 0);
      chk(rx_ready == 1'b1, "R4 ready set", rx_ready, 1);
      chk(irq == 1'b0, "R10 irq masked", irq, 0);
      irq_en = 1'b1;
      @(negedge clk);
      chk(irq == 1'b1, "R10 irq with enable", irq, 1);
      chk(overrun == 1'b0, "R6 no overrun yet", overrun, 0);
      send_async(8'h22, 0, 0, 0);
      chk(overrun == 1'b1, "R6 overrun set", overrun, 1);
      chk(rx_data == 8'h22, "R6 data overwritten", rx_data, 8'h22);
      @(negedge clk) tst_clr = 1'b1;
      @(negedge clk) tst_clr = 1'b0;
      chk(overrun == 1'b0, "R9 overrun cleared", overrun, 0);
      chk(rx_ready == 1'b1, "R9 ready untouched", rx_ready, 1);
      chk(rx_data == 8'h22, "R9 data untouched", rx_data, 8'h22);
      @(negedge clk) tst_rd = 1'b1;
      @(negedge clk) tst_rd = 1'b0;
      chk(rx_ready == 1'b0, "R5 manual read", rx_ready, 0);
      chk(irq == 1'b0, "R10 irq follows ready", irq, 0);

      // R8 R9: sticky framing flag survives until clear
      send_async(8'h44, 0, 1, 0);
      @(negedge clk) tst_rd = 1'b1;
      @(negedge clk) tst_rd = 1'b0;
      repeat (10) @(negedge clk);
      chk(frame_err == 1'b1, "R8 frame flag sticky", frame_err, 1);
      @(negedge clk) tst_clr = 1'b1;
      @(negedge clk) tst_clr = 1'b0;
      chk(frame_err == 1'b0, "R9 frame flag cleared", frame_err, 0);

      finish_run();
   end
endmodule